// File: doc/BRIEF.md
# Limit-Compare Interval Timer Group

This block holds a set of interval timers behind a small word-addressed register port. One system timer feeds the level 10 interrupt line; one timer per processor feeds that processor's level 14 line. Every timer counts `tick` pulses from an external prescaler. When the count matches a programmed nonzero limit, the count starts again from zero and the timer's pending flag is set. The flag holds its interrupt line high until software reads the timer's limit word. A second word reads back the same limit without clearing the flag. The count word can be read at any time, so software can use it as a free-running clock.

Each processor timer can also be switched into a free counter mode through a shared mode word. In that mode a run bit starts and stops the count, and the limit is not used. Writing zero to the mode word returns every processor timer to interval mode. Processor timer `i` takes words `4*i` to `4*i+3`. The system timer follows at `4*NUM_CPU`. The mode word is at `4*NUM_CPU+4`. Reads are combinational. Writes and read side effects take place at the rising clock edge on which the strobe is high.

Top module: `tmr_group`

## Requirements
- R1: After reset every limit, count, run bit and the mode word read 0, and `irq_sys` and `irq_cpu` are low.
- R2: In interval mode a timer's count goes up by one on each clock edge where `tick` is 1, and holds where `tick` is 0. The count is word offset 1 of a timer (processor timer `i` at word `4*i+1`). It can be read at any time with no side effect. Writes to it are ignored.
- R3: When `tick` is 1 and the count equals a nonzero limit, that edge reloads the count to 0 and sets the pending flag. The interrupt line is high from the following cycle on.
- R4: A pending flag stays set through any number of further ticks and count reads until it is acknowledged.
- R5: A read of word offset 2 (no-clear alias) returns the limit in the low `CNT_W` bits and leaves the pending flag set.
- R6: A read of word offset 0 returns the limit and clears the pending flag at that edge.
- R7: With a limit of 0 a timer never sets its pending flag, and its count runs modulo 2^`CNT_W`.
- R8: A write to word offset 0 or 2 loads the limit and restarts the count at 0. The write takes priority over a tick on the same edge.
- R9: With mode word bit `i` set to 1, processor timer `i` counts ticks only while its run bit (word offset 3, bit 0) is 1. It ignores the limit and never sets its pending flag. The run bit reads back at offset 3.
- R10: The mode word (word `4*NUM_CPU+4`, bit `i` for processor timer `i`) reads back as written. Writing 0 to it puts every processor timer back in interval mode.
- R11: The system timer (words `4*NUM_CPU`+0..2) drives only `irq_sys` and has no free counter mode. Its word offset 3 reads 0 and ignores writes.
- R12: When a limit match and an acknowledging read fall on the same edge, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Count enable from the external prescaler |
| rd_en | input | 1 | Read strobe; read side effects occur at the edge |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq_sys | output | 1 | Level 10 request from the system timer |
| irq_cpu | output | NUM_CPU | Level 14 requests, one per processor timer |

## Verification
Interval counting is tried with a partial run below the limit, a run that crosses the match, and a run that continues well past it. The partial run and the crossing run separate the count step from the reload. Continuing past the match tells a held flag from a one-cycle pulse. A zero limit driven through more than one full count span separates a count that wraps at its width from one that stops or raises a flag. In free counter mode the bench drives ticks with the run bit low and then high, with a count past the limit, which tells run gating apart from limit matching. A match that coincides with an acknowledging read shows which of the two wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    OFS_LIMIT    = 2'd0,
    OFS_COUNT    = 2'd1,
    OFS_LIMIT_NC = 2'd2,
    OFS_CTRL     = 2'd3
  } tmr_ofs_e;

  typedef struct packed {
    logic lim_wr;
    logic ctl_wr;
    logic ack;
  } chan_cmd_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_regdec.sv
module tmr_regdec
  import tmr_pkg::*;
#(
  parameter int NCH   = 5,
  parameter int BLK_W = 3
) (
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic [BLK_W+1:0]      addr,
  output chan_cmd_t [NCH-1:0]   cmd,
  output logic                  cfg_wr,
  output logic [BLK_W-1:0]      blk,
  output tmr_ofs_e              ofs
);
  always_comb begin
    blk = addr[BLK_W+1:2];
    ofs = tmr_ofs_e'(addr[1:0]);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmd
    logic hit;
    assign hit = (blk == BLK_W'(i));
    always_comb begin
      cmd[i].lim_wr = wr_en && hit && (ofs == OFS_LIMIT || ofs == OFS_LIMIT_NC);
      cmd[i].ctl_wr = wr_en && hit && (ofs == OFS_CTRL);
      cmd[i].ack    = rd_en && hit && (ofs == OFS_LIMIT);
    end
  end

  assign cfg_wr = wr_en && (blk == BLK_W'(NCH)) && (ofs == OFS_LIMIT);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W    = 22,
  parameter bit HAS_CTRL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             tick,
  input  logic             user_mode,
  input  logic             lim_wr,
  input  logic             ctl_wr,
  input  logic             ack,
  input  logic [CNT_W-1:0] wdata,
  input  logic             wbit0,
  output logic [CNT_W-1:0] limit_q,
  output logic [CNT_W-1:0] count_q,
  output logic             run_q,
  output logic             pend_q
);
  logic [CNT_W-1:0] lim_d, cnt_d;
  logic             pend_d;
  logic             cnt_en, lim_en;
  logic             match;

  assign match  = (limit_q != '0) && (count_q == limit_q);
  assign cnt_en = lim_wr || tick;
  assign lim_en = lim_wr;

  always_comb begin
    lim_d  = wdata;
    cnt_d  = count_q;
    pend_d = pend_q;
    if (ack) pend_d = 1'b0;
    if (lim_wr) begin
      cnt_d = '0;
    end else if (tick) begin
      if (user_mode) begin
        if (run_q) cnt_d = count_q + CNT_W'(1);
      end else if (match) begin
        cnt_d  = '0;
        pend_d = 1'b1;
      end else begin
        cnt_d = count_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      limit_q <= '0;
      count_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (lim_en) limit_q <= lim_d;
      if (cnt_en) count_q <= cnt_d;
      pend_q <= pend_d;
    end
  end

  if (HAS_CTRL) begin : g_run
    logic run_d;
    assign run_d = ctl_wr ? wbit0 : run_q;
    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) run_q <= 1'b0;
      else         run_q <= run_d;
    end
  end else begin : g_norun
    assign run_q = 1'b0;
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    tick && !user_mode && !lim_wr && limit_q != '0 && count_q == limit_q
      |=> count_q == '0 && pend_q);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    pend_q && !ack |=> pend_q);
  p_ack_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    ack && !tick |=> !pend_q);
  p_zero_limit_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    limit_q == '0 && !pend_q |=> !pend_q);
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    lim_wr |=> count_q == '0);
  p_user_quiet_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    user_mode && !pend_q |=> !pend_q);
endmodule

// File: rtl/tmr_group.sv
module tmr_group
  import tmr_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CNT_W   = 22,
  parameter int DATA_W  = 32,
  localparam int BLK_W  = $clog2(NUM_CPU + 2),
  localparam int ADDR_W = BLK_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_sys,
  output logic [NUM_CPU-1:0] irq_cpu
);
  localparam int NCH = NUM_CPU + 1;
  localparam int SYS = NUM_CPU;

  logic                 rst_ns;
  chan_cmd_t [NCH-1:0]  cmd;
  logic                 cfg_wr;
  logic [BLK_W-1:0]     blk;
  tmr_ofs_e             ofs;
  logic [NUM_CPU-1:0]   cfg_q, cfg_d;
  logic [CNT_W-1:0]     lim_v [NCH];
  logic [CNT_W-1:0]     cnt_v [NCH];
  logic [NCH-1:0]       run_v;
  logic [NCH-1:0]       pend_v;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  tmr_regdec #(.NCH(NCH), .BLK_W(BLK_W)) u_dec (
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .cmd(cmd), .cfg_wr(cfg_wr), .blk(blk), .ofs(ofs)
  );

  assign cfg_d = cfg_wr ? wdata[NUM_CPU-1:0] : cfg_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic umode;
    if (i < NUM_CPU) begin : g_cpu
      assign umode = cfg_q[i];
    end else begin : g_sys
      assign umode = 1'b0;
    end
    tmr_channel #(.CNT_W(CNT_W), .HAS_CTRL(i < NUM_CPU)) u_ch (
      .clk(clk), .rst_ns(rst_ns), .tick(tick), .user_mode(umode),
      .lim_wr(cmd[i].lim_wr), .ctl_wr(cmd[i].ctl_wr), .ack(cmd[i].ack),
      .wdata(wdata[CNT_W-1:0]), .wbit0(wdata[0]),
      .limit_q(lim_v[i]), .count_q(cnt_v[i]),
      .run_q(run_v[i]), .pend_q(pend_v[i])
    );
  end

  always_comb begin
    rdata = '0;
    if (blk < BLK_W'(NCH)) begin
      case (ofs)
        OFS_LIMIT, OFS_LIMIT_NC: rdata[CNT_W-1:0] = lim_v[blk];
        OFS_COUNT:               rdata[CNT_W-1:0] = cnt_v[blk];
        default:                 rdata[0]         = run_v[blk];
      endcase
    end else if (blk == BLK_W'(NCH) && ofs == OFS_LIMIT) begin
      rdata[NUM_CPU-1:0] = cfg_q;
    end
  end

  assign irq_cpu = pend_v[NUM_CPU-1:0];
  assign irq_sys = pend_v[SYS];

  p_sys_norun_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    !run_v[SYS]);
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    !cfg_wr |=> $stable(cfg_q));
endmodule

// File: tb/sim_tmr_group.sv
module sim_tmr_group;
  localparam int NUM_CPU = 4;
  localparam int CNT_W   = 8;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = $clog2(NUM_CPU + 2) + 2;
  localparam int SYSB    = 4 * NUM_CPU;
  localparam int CFGA    = 4 * NUM_CPU + 4;

  logic clk, rst_n, tick, rd_en, wr_en;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  wdata, rdata;
  logic               irq_sys;
  logic [NUM_CPU-1:0] irq_cpu;
  int checks = 0;
  int errors = 0;

  tmr_group #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_sys(irq_sys), .irq_cpu(irq_cpu)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic bus_wr(input int a, input int d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = DATA_W'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input int a, input bit tk, output int d);
    @(negedge clk);
    addr = ADDR_W'(a); rd_en = 1'b1; tick = tk;
    #1 d = int'(rdata);
    @(negedge clk);
    rd_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    int d;
    chk("R1 irq_cpu", irq_cpu, 0);
    chk("R1 irq_sys", irq_sys, 0);
    bus_rd(1, 0, d);    chk("R1 count", d, 0);
    bus_rd(2, 0, d);    chk("R1 limit", d, 0);
    bus_rd(3, 0, d);    chk("R1 run", d, 0);
    bus_rd(CFGA, 0, d); chk("R1 mode word", d, 0);
  endtask

  task automatic t_interval;
    int d;
    bus_wr(0, 5);
    ticks(3);
    bus_rd(1, 0, d); chk("R2 count after 3 ticks", d, 3);
    chk("R2 no irq below limit", irq_cpu, 0);
    repeat (5) @(negedge clk);
    bus_rd(1, 0, d); chk("R2 count holds without tick", d, 3);
    bus_wr(1, 77);
    bus_rd(1, 0, d); chk("R2 count write ignored", d, 3);
    ticks(3);
    bus_rd(1, 0, d); chk("R3 count reloaded", d, 0);
    chk("R3 irq raised", irq_cpu, 1);
    ticks(4);
    bus_rd(1, 0, d); chk("R4 count after match", d, 4);
    chk("R4 irq held", irq_cpu, 1);
    bus_rd(2, 0, d); chk("R5 alias value", d, 5);
    chk("R5 irq after alias read", irq_cpu, 1);
    bus_rd(0, 0, d); chk("R6 limit value", d, 5);
    chk("R6 irq cleared", irq_cpu, 0);
  endtask

  task automatic t_restart;
    int d;
    bus_wr(2, 9);
    bus_rd(1, 0, d); chk("R8 count restarted via alias", d, 0);
    bus_rd(2, 0, d); chk("R8 limit loaded via alias", d, 9);
    ticks(2);
    bus_wr(0, 7);
    bus_rd(1, 0, d); chk("R8 count restarted", d, 0);
  endtask

  task automatic t_zero_limit;
    int d;
    bus_wr(0, 0);
    ticks(300);
    bus_rd(1, 0, d); chk("R7 count modulo width", d, 300 % 256);
    chk("R7 no irq with zero limit", irq_cpu, 0);
  endtask

  task automatic t_user;
    int d;
    bus_wr(CFGA, 2);
    bus_rd(CFGA, 0, d); chk("R10 mode readback", d, 2);
    bus_wr(4, 3);
    ticks(5);
    bus_rd(5, 0, d); chk("R9 stopped count", d, 0);
    bus_wr(7, 1);
    bus_rd(7, 0, d); chk("R9 run readback", d, 1);
    ticks(10);
    bus_rd(5, 0, d); chk("R9 count past limit", d, 10);
    chk("R9 no irq in free mode", irq_cpu, 0);
    bus_wr(CFGA, 0);
    bus_wr(4, 3);
    ticks(4);
    chk("R10 interval mode back", irq_cpu, 2);
    bus_rd(4, 0, d);
    chk("R10 ack", irq_cpu, 0);
    bus_wr(4, 0);
  endtask

  task automatic t_system;
    int d;
    bus_wr(SYSB + 3, 1);
    bus_rd(SYSB + 3, 0, d); chk("R11 fourth word reads 0", d, 0);
    bus_wr(SYSB, 2);
    ticks(3);
    chk("R11 irq_sys raised", irq_sys, 1);
    chk("R11 cpu lines quiet", irq_cpu, 0);
    bus_rd(SYSB + 1, 0, d); chk("R11 count reloaded", d, 0);
    bus_rd(SYSB, 0, d); chk("R11 limit value", d, 2);
    chk("R11 irq_sys cleared", irq_sys, 0);
    bus_wr(SYSB, 0);
  endtask

  task automatic t_collide;
    int d;
    bus_wr(8, 2);
    ticks(2);
    bus_rd(8, 1, d);
    chk("R12 set wins over ack", irq_cpu, 4);
    bus_rd(8, 0, d);
    chk("R12 later ack clears", irq_cpu, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_interval();
    t_restart();
    t_zero_limit();
    t_user();
    t_system();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule